// File: doc/BRIEF.md
# Link Interrupt Aggregator

The block gathers interrupt conditions from eight links and folds them into one active-low interrupt pin. Each link has an 8-bit status register. Most of its bits are sticky flags that a one-cycle pulse sets and a write of zero clears. One bit in every link, and one further bit in link 0 only, follow a level-sensitive source directly. These bits fall only when that source is serviced outside the block.

A second level combines the links. A read-only master status register shows which links hold a nonzero status. A read/write master enable register selects which of those links may pull the pin low. Software reaches all registers through a plain port with address, write data and a write strobe that takes effect on the clock edge. Reads are combinational through a read mux.

Top module: `link_irq_aggr`

## Requirements
- R1: After the asynchronous reset, every link status register, the master status and the master enable read 0x00, and irq_no is high.
- R2: A one-cycle pulse on a link's event input sets that link's sticky bit on the next clock edge, and the bit then holds. The bit positions are: cell_chg_i to bit 5, cell_viol_i to bit 4, dly_oos_i to bit 3, frm_loss_i to bit 2 and cell_del_i to bit 1.
- R3: A write to a link status address clears each sticky bit whose write-data bit is 0. A write-data bit of 1 leaves its sticky bit unchanged.
- R4: When a set pulse and a clearing write reach the same sticky bit in the same cycle, the bit ends up set.
- R5: Bit 0 of link i reads the live level of cnt_ovf_i[i] in the same cycle. Writes do not change it.
- R6: In link 0 only, bit 7 reads the live level of grp_ovf_i and ignores writes. Bit 6 is a sticky bit that tx_done_i sets and a write of 0 clears.
- R7: In links 1 to 7, bits 7 and 6 always read 0, whatever happens on grp_ovf_i, tx_done_i or the write data.
- R8: Master status bit i reads 1 exactly when link i status is nonzero. Writes to the master status address have no effect.
- R9: Master enable is read/write, one bit per link. irq_no is low exactly when some link has both its master status bit and its enable bit set. The pin follows status and enable changes with no added latency.
- R10: Address map: 0 to 7 select the link status registers, 8 selects the master status and 9 the master enable. Reads of addresses 10 to 15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, sampled on the clock edge |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| cell_chg_i | input | 8 | Per-link pulse: control cell with changes received |
| cell_viol_i | input | 8 | Per-link pulse: control cell violation |
| dly_oos_i | input | 8 | Per-link pulse: delay synchronisation lost |
| frm_loss_i | input | 8 | Per-link pulse: frame lost |
| cell_del_i | input | 8 | Per-link pulse: cell delineation lost |
| cnt_ovf_i | input | 8 | Per-link level: counter overflow pending |
| grp_ovf_i | input | 1 | Level: group overflow sources pending (link 0) |
| tx_done_i | input | 1 | Pulse: transmit control cell done or group frame pulse (link 0) |
| irq_no | output | 1 | Interrupt pin, active low |

## Verification
Two functions can meet in one cycle: a pulse that sets a sticky bit and a software write that clears the same bit. A directed step drives cell_del_i on a link together with a zero write to that link's address. The bench then reads the register and expects the bit to remain set. The random phase also drives event pulses together with link writes of random data. In that phase, a behavioural model that applies the clear first and the set second decides every read and the pin level on every cycle. A second overlap puts an enable write and a live level change in the same cycle. The bench judges the pin in the same cycle the level moves.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W = 8;

  // bit layout of a link status register
  localparam int unsigned B_GRP_OVF   = 7;
  localparam int unsigned B_TX_DONE   = 6;
  localparam int unsigned B_CELL_CHG  = 5;
  localparam int unsigned B_CELL_VIOL = 4;
  localparam int unsigned B_DLY_OOS   = 3;
  localparam int unsigned B_FRM_LOSS  = 2;
  localparam int unsigned B_CELL_DEL  = 1;
  localparam int unsigned B_CNT_OVF   = 0;

  localparam logic [REG_W-1:0] STICKY_MASK_L0 = 8'h7E;
  localparam logic [REG_W-1:0] STICKY_MASK_LN = 8'h3E;

  // order matches bits 5 down to 1
  typedef struct packed {
    logic cell_chg;
    logic cell_viol;
    logic dly_oos;
    logic frm_loss;
    logic cell_del;
  } link_evt_t;
endpackage

// File: rtl/link_stat_reg.sv
module link_stat_reg
  import irq_agg_pkg::*;
#(
  parameter bit HAS_GRP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  link_evt_t        evt_i,
  input  logic             cnt_ovf_i,
  input  logic             grp_ovf_i,
  input  logic             tx_done_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] stat_o
);
  localparam logic [REG_W-1:0] MASK = HAS_GRP ? STICKY_MASK_L0 : STICKY_MASK_LN;

  logic [REG_W-1:0] sticky_q, sticky_d, set_vec, keep_vec, live_vec;

  generate
    if (HAS_GRP) begin : g_grp
      always_comb begin
        set_vec  = {1'b0, tx_done_i, evt_i, 1'b0};
        live_vec = {grp_ovf_i, 6'b0, cnt_ovf_i};
      end
    end else begin : g_plain
      logic unused_grp;
      assign unused_grp = grp_ovf_i ^ tx_done_i;
      always_comb begin
        set_vec  = {2'b00, evt_i, 1'b0};
        live_vec = {7'b0, cnt_ovf_i};
      end
    end
  endgenerate

  assign keep_vec = wr_i ? wdata_i : '1;
  // clear first, then set: a same-cycle event survives the write
  assign sticky_d = ((sticky_q & keep_vec) | set_vec) & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  assign stat_o = sticky_q | live_vec;
endmodule

// File: rtl/irq_master.sv
module irq_master
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_wr_i,
  input  logic [REG_W-1:0]           wdata_i,
  input  logic [NUM_LINKS*REG_W-1:0] stat_flat_i,
  output logic [NUM_LINKS-1:0]       mstat_o,
  output logic [NUM_LINKS-1:0]       en_o,
  output logic                       irq_no
);
  logic [NUM_LINKS-1:0] en_q;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_req
    assign mstat_o[i] = |stat_flat_i[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= wdata_i[NUM_LINKS-1:0];
  end

  assign en_o   = en_q;
  assign irq_no = ~|(mstat_o & en_q);
endmodule

// File: rtl/link_irq_aggr.sv
module link_irq_aggr
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8,
  localparam int unsigned AW = $clog2(NUM_LINKS + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 we_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [NUM_LINKS-1:0] cell_chg_i,
  input  logic [NUM_LINKS-1:0] cell_viol_i,
  input  logic [NUM_LINKS-1:0] dly_oos_i,
  input  logic [NUM_LINKS-1:0] frm_loss_i,
  input  logic [NUM_LINKS-1:0] cell_del_i,
  input  logic [NUM_LINKS-1:0] cnt_ovf_i,
  input  logic                 grp_ovf_i,
  input  logic                 tx_done_i,
  output logic                 irq_no
);
  localparam logic [AW-1:0] ADDR_MSTAT = AW'(NUM_LINKS);
  localparam logic [AW-1:0] ADDR_MEN   = AW'(NUM_LINKS + 1);

  logic [NUM_LINKS*REG_W-1:0] stat_flat;
  logic [NUM_LINKS-1:0]       mstat, en_q;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    link_evt_t evt;
    assign evt = '{cell_chg:  cell_chg_i[i],
                   cell_viol: cell_viol_i[i],
                   dly_oos:   dly_oos_i[i],
                   frm_loss:  frm_loss_i[i],
                   cell_del:  cell_del_i[i]};

    link_stat_reg #(.HAS_GRP(i == 0)) u_stat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt),
      .cnt_ovf_i (cnt_ovf_i[i]),
      .grp_ovf_i (grp_ovf_i),
      .tx_done_i (tx_done_i),
      .wr_i      (we_i && (addr_i == AW'(i))),
      .wdata_i   (wdata_i),
      .stat_o    (stat_flat[i*REG_W +: REG_W])
    );
  end

  irq_master #(.NUM_LINKS(NUM_LINKS)) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_wr_i     (we_i && (addr_i == ADDR_MEN)),
    .wdata_i     (wdata_i),
    .stat_flat_i (stat_flat),
    .mstat_o     (mstat),
    .en_o        (en_q),
    .irq_no      (irq_no)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (addr_i == AW'(i)) rdata_o = stat_flat[i*REG_W +: REG_W];
    end
    if (addr_i == ADDR_MSTAT) rdata_o = REG_W'(mstat);
    if (addr_i == ADDR_MEN)   rdata_o = REG_W'(en_q);
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8,
  localparam int unsigned AW = $clog2(NUM_LINKS + 2)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       we_i,
  input logic [AW-1:0]              addr_i,
  input logic [REG_W-1:0]           wdata_i,
  input logic [NUM_LINKS-1:0]       cell_del_i,
  input logic [NUM_LINKS-1:0]       cnt_ovf_i,
  input logic                       grp_ovf_i,
  input logic [NUM_LINKS*REG_W-1:0] stat_flat_i,
  input logic [NUM_LINKS-1:0]       mstat_i,
  input logic [NUM_LINKS-1:0]       en_i,
  input logic                       irq_ni
);
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_chk
    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cell_del_i[i] |=> stat_flat_i[i*REG_W + 1]);

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_flat_i[i*REG_W + 1] && !(we_i && addr_i == AW'(i))) |=> stat_flat_i[i*REG_W + 1]);

    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == AW'(i) && !wdata_i[1] && !cell_del_i[i]) |=> !stat_flat_i[i*REG_W + 1]);

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == AW'(i) && !wdata_i[1] && cell_del_i[i]) |=> stat_flat_i[i*REG_W + 1]);

    p_live_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_flat_i[i*REG_W] == cnt_ovf_i[i]);

    p_mstat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mstat_i[i] == (|stat_flat_i[i*REG_W +: REG_W]));

    if (i > 0) begin : g_upper
      p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_flat_i[i*REG_W + 6 +: 2] == 2'b00);
    end
  end

  p_live_grp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_flat_i[B_GRP_OVF] == grp_ovf_i);

  p_en_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(NUM_LINKS + 1)) |=> en_i == $past(wdata_i[NUM_LINKS-1:0]));

  p_irq_link0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|stat_flat_i[REG_W-1:0]) && en_i[0]) |-> !irq_ni);
endmodule

bind link_irq_aggr irq_agg_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .cell_del_i  (cell_del_i),
  .cnt_ovf_i   (cnt_ovf_i),
  .grp_ovf_i   (grp_ovf_i),
  .stat_flat_i (stat_flat),
  .mstat_i     (mstat),
  .en_i        (en_q),
  .irq_ni      (irq_no)
);

// File: tb/tb_link_irq_aggr.sv
module tb_link_irq_aggr;
  localparam int N = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [3:0]    addr;
  logic [7:0]    wdata;
  logic          we;
  logic [7:0]    rdata;
  logic [N-1:0]  chg, viol, oos, frm, del, cov;
  logic          grp, txd;
  logic          irq_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] m_sticky [N];
  logic [7:0] m_en;

  link_irq_aggr #(.NUM_LINKS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .cell_chg_i(chg), .cell_viol_i(viol), .dly_oos_i(oos),
    .frm_loss_i(frm), .cell_del_i(del), .cnt_ovf_i(cov), .grp_ovf_i(grp),
    .tx_done_i(txd), .irq_no(irq_n)
  );

  function automatic logic [7:0] m_stat(int i);
    logic [7:0] v;
    v    = m_sticky[i];
    v[0] = cov[i];
    if (i == 0) v[7] = grp;
    return v;
  endfunction

  function automatic logic [7:0] m_read(logic [3:0] a);
    logic [7:0] s;
    s = 8'h00;
    if (a < 4'(N)) s = m_stat(int'(a));
    else if (a == 4'd8) begin
      for (int i = 0; i < N; i++) s[i] = |m_stat(i);
    end else if (a == 4'd9) s = m_en;
    return s;
  endfunction

  function automatic logic m_irq_n();
    for (int i = 0; i < N; i++)
      if ((|m_stat(i)) && m_en[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (addr %0d, t=%0t)", tag, got, exp, addr, $time);
    end
  endtask

  task automatic model_update();
    for (int i = 0; i < N; i++) begin
      logic [7:0] s, mask;
      mask = (i == 0) ? 8'h7E : 8'h3E;
      s = m_sticky[i];
      if (we && addr == 4'(i)) s = s & wdata;
      s = s | {1'b0, (i == 0) && txd, chg[i], viol[i], oos[i], frm[i], del[i], 1'b0};
      m_sticky[i] = s & mask;
    end
    if (we && addr == 4'd9) m_en = wdata;
  endtask

  task automatic clr_pulses();
    we = 1'b0; chg = '0; viol = '0; oos = '0; frm = '0; del = '0; txd = 1'b0;
  endtask

  // inputs are set at a negedge; sample 2 ns later, then advance one cycle
  task automatic step(string tag);
    #2;
    chk({tag, " rdata"}, rdata, m_read(addr));
    chk("R9 irq_no", {7'b0, irq_n}, {7'b0, m_irq_n()});
    if (rst_n) model_update();
    @(posedge clk);
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic rd(logic [3:0] a, string tag);
    addr = a; we = 1'b0; step(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
    addr = a; wdata = d; we = 1'b1; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; cov = '0; grp = 1'b0;
    clr_pulses();
    for (int i = 0; i < N; i++) m_sticky[i] = 8'h00;
    m_en = 8'h00;
    repeat (2) @(negedge clk);
    // R1: values held in reset
    for (int a = 0; a < 10; a++) rd(4'(a), "R1 reset value");
    rst_n = 1'b1;
    for (int a = 0; a < 10; a++) rd(4'(a), "R1 after reset");

    // R2: each event type sets its bit and the bit holds
    chg[3] = 1'b1; rd(3, "R2 cell_chg");
    rd(3, "R2 cell_chg set"); rd(3, "R2 cell_chg hold");
    del[7] = 1'b1; frm[7] = 1'b1; rd(7, "R2 del+frm");
    rd(7, "R2 del+frm set");
    viol[2] = 1'b1; oos[2] = 1'b1; rd(2, "R2 viol+oos");
    rd(2, "R2 viol+oos set");

    // R3: write-zero clears, write-one keeps
    wr(3, 8'hFF, "R3 write ones"); rd(3, "R3 ones keep");
    wr(7, 8'hFB, "R3 clear bit2"); rd(7, "R3 bit1 kept bit2 cleared");
    wr(2, 8'h00, "R3 clear all"); rd(2, "R3 cleared");

    // R4: same-cycle set and clear
    del[5] = 1'b1; rd(5, "R4 prep");
    del[5] = 1'b1; wr(5, 8'h00, "R4 set vs clear"); rd(5, "R4 set wins");
    chg[5] = 1'b1; wr(5, 8'h00, "R4 clear bit1 set bit5"); rd(5, "R4 result");

    // R5: live counter overflow bit
    cov[2] = 1'b1; rd(2, "R5 level visible same cycle");
    wr(2, 8'h00, "R5 write zero"); rd(2, "R5 bit0 unaffected");
    cov[2] = 1'b0; rd(2, "R5 level released");

    // R6: link 0 extra bits
    grp = 1'b1; rd(0, "R6 grp live");
    wr(0, 8'h00, "R6 write zero"); rd(0, "R6 grp unaffected");
    grp = 1'b0; rd(0, "R6 grp released");
    txd = 1'b1; rd(0, "R6 tx pulse"); rd(0, "R6 tx set");
    wr(0, 8'hBF, "R6 clear bit6"); rd(0, "R6 tx cleared");

    // R7: upper bits absent on links 1..7
    grp = 1'b1; txd = 1'b1; rd(1, "R7 link1 upper");
    for (int a = 1; a < 8; a++) rd(4'(a), "R7 upper zero");
    wr(4, 8'hFF, "R7 write ones"); rd(4, "R7 still zero");
    grp = 1'b0; rd(0, "R6 grp drop");

    // R8: master status read-only
    wr(8, 8'hFF, "R8 write"); rd(8, "R8 unchanged");
    wr(8, 8'h00, "R8 write zero"); rd(8, "R8 unchanged 2");

    // R9: enable gating and immediate pin response
    for (int a = 0; a < 8; a++) wr(4'(a), 8'h00, "R9 clean");
    chg[6] = 1'b1; rd(6, "R9 link6 pending disabled");
    wr(9, 8'h40, "R9 enable link6"); rd(9, "R9 enable readback");
    wr(9, 8'h00, "R9 disable"); rd(8, "R9 mstat");
    wr(9, 8'h02, "R9 enable link1"); rd(1, "R9 idle link1");
    cov[1] = 1'b1; rd(1, "R9 level drives pin same cycle");
    cov[1] = 1'b0; rd(1, "R9 level released");
    wr(6, 8'h00, "R9 clear link6"); rd(8, "R9 mstat cleared");

    // R10: unused addresses
    for (int a = 10; a < 16; a++) rd(4'(a), "R10 unused addr");

    // mixed random traffic, model decides every cycle
    for (int k = 0; k < 600; k++) begin
      addr  = 4'($urandom_range(0, 15));
      wdata = 8'($urandom);
      we    = ($urandom_range(0, 3) == 0);
      chg   = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      viol  = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      oos   = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      frm   = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      del   = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      txd   = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) cov = N'($urandom);
      if ($urandom_range(0, 9) == 0) grp = 1'($urandom);
      step("random R2 R3 R4 R5 R6 R7 R8 R10");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule